// File: doc/BRIEF.md
# Slot Network Interrupt Collector

This block gathers per-port network interrupt requests from plug-in module slots and keeps them as sticky status bits that the processor reads back. Two request channels, one that raises a bit and one that drops it, each carry a slot number and a port number. The block maps each (slot, port) pair to one bit of two status words. It also drives a single combined network interrupt line. The bit positions depend on the chassis mode and are deliberately irregular, so software must use the same fixed layout to find a slot's lines.

The chassis mode is sampled while reset is held. In the four-slot mode every slot lands in status word 0, and the processor reads that word as four byte registers whose addresses are permuted against slot numbers. In the seven-slot mode slot 0 moves to a separate narrow word 1, slots 1 to 6 fill word 0, and the processor reads the two words as one wide and one narrow register.

The interrupt line comes from a two-state controller. `ST_QUIET` means no relevant status bit is set. Transition *raise* goes `ST_QUIET` to `ST_RAISED` when the next status holds any set bit. Transition *settle* goes `ST_RAISED` to `ST_QUIET` when the next status is all clear. Reset enters `ST_QUIET`.

Top module: `netirq_collector`

## Requirements
- R1: While and after reset, both status words are zero, every read select returns zero and `irq_o` is low.
- R2: An accepted raise request sets its mapped bit on the next clock, and all other bits keep their values.
- R3: An accepted drop request clears only its mapped bit on the next clock.
- R4: When a raise and a drop map to the same bit in one cycle, the bit ends up set.
- R5: Mode value 0 (four slots): slots 0, 1, 2, 3 map to word 0 at base bits 16, 24, 0, 8, with the port added to the base. Word 1 is never written.
- R6: Mode value 0: read select 0 returns word 0 bits 31:24, select 1 bits 23:16, select 2 bits 15:8, select 3 bits 7:0, zero-extended to 32 bits. Select 4 to 7 returns zero.
- R7: Mode value 1 (seven slots): slot 0 maps to word 1 at base 0. Slots 1 to 6 map to word 0 at bases 24, 16, 28, 20, 8, 0.
- R8: Mode value 1: select 0 returns all of word 0, select 1 returns the 8-bit word 1 zero-extended, and selects 2 to 7 return zero.
- R9: `irq_o` is high exactly when a status bit is set: word 0 in mode 0, word 0 or word 1 in mode 1. It follows the status in the same cycle.
- R10: Requests whose slot is not below the mode's slot count (4 or 7), or whose port is above 3, change no status bit.
- R11: The mode input is captured only while `rst_n` is low. Changing it after reset has no effect on mapping, reads or the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode is captured while low |
| mode_i | input | 1 | Chassis mode: 0 four slots, 1 seven slots |
| set_vld_i | input | 1 | Raise request valid |
| set_slot_i | input | 3 | Raise request slot |
| set_port_i | input | 3 | Raise request port |
| clr_vld_i | input | 1 | Drop request valid |
| clr_slot_i | input | 3 | Drop request slot |
| clr_port_i | input | 3 | Drop request port |
| rd_sel_i | input | 3 | Read register select |
| rd_data_o | output | 32 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Combined network interrupt |

## Verification
Errors in the status words show up at the read port in the first cycle after the request that caused them: a mis-placed base offset sets the wrong bit, and a broken byte permutation returns another slot's lines. A controller state that does not match the status shows up as an interrupt level that disagrees with the read-back words in that same cycle. A mode register that reloads after reset turns later requests for slots 4 to 6 into visible bits, or moves slot 0 between words. Because each of these faults reaches a port within one clock, a reference model compared on every clock over directed and random requests in both modes catches it at once.

// File: rtl/netirq_pkg.sv
package netirq_pkg;

    typedef enum logic {
        MODE_QUAD = 1'b0,
        MODE_SEPT = 1'b1
    } chassis_mode_e;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic       in_w1;
        logic [7:0] base;
    } slot_place_t;

    // Fixed bit placement of each slot's four port lines.
    function automatic slot_place_t place_of(chassis_mode_e m, logic [2:0] slot);
        slot_place_t p;
        p.in_w1 = 1'b0;
        p.base  = 8'd0;
        if (m == MODE_QUAD) begin
            unique case (slot[1:0])
                2'd0: p.base = 8'd16;
                2'd1: p.base = 8'd24;
                2'd2: p.base = 8'd0;
                2'd3: p.base = 8'd8;
            endcase
        end else begin
            unique case (slot)
                3'd0: begin p.in_w1 = 1'b1; p.base = 8'd0; end
                3'd1: p.base = 8'd24;
                3'd2: p.base = 8'd16;
                3'd3: p.base = 8'd28;
                3'd4: p.base = 8'd20;
                3'd5: p.base = 8'd8;
                3'd6: p.base = 8'd0;
                3'd7: p.base = 8'd0;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/netirq_decode.sv
module netirq_decode
    import netirq_pkg::*;
#(
    parameter int W0         = 32,
    parameter int W1         = 8,
    parameter int SLOT_W     = 3,
    parameter int PORT_W     = 3,
    parameter int PORTS      = 4,
    parameter int SLOTS_QUAD = 4,
    parameter int SLOTS_SEPT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chassis_mode_e     mode,
    input  logic              vld,
    input  logic [SLOT_W-1:0] slot,
    input  logic [PORT_W-1:0] port,
    output logic [W0-1:0]     mask0,
    output logic [W1-1:0]     mask1
);
    localparam int IW0 = $clog2(W0);
    localparam int IW1 = $clog2(W1);
    localparam logic [SLOT_W-1:0] LIM_Q = SLOT_W'(SLOTS_QUAD);
    localparam logic [SLOT_W-1:0] LIM_S = SLOT_W'(SLOTS_SEPT);
    localparam logic [PORT_W-1:0] LIM_P = PORT_W'(PORTS);

    slot_place_t       pl;
    logic [SLOT_W-1:0] lim;
    logic [IW0-1:0]    idx0;
    logic [IW1-1:0]    idx1;
    logic              accept;

    always_comb begin
        lim    = (mode == MODE_SEPT) ? LIM_S : LIM_Q;
        accept = vld && (slot < lim) && (port < LIM_P);
        pl     = place_of(mode, 3'(slot));
        idx0   = IW0'(pl.base) + IW0'(port);
        idx1   = IW1'(pl.base) + IW1'(port);
        mask0  = '0;
        mask1  = '0;
        if (accept) begin
            if (pl.in_w1) mask1[idx1] = 1'b1;
            else          mask0[idx0] = 1'b1;
        end
    end

    // A request never touches more than one status bit.
    p_single_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mask0, mask1}));

    // The narrow word is unused in the four-slot mode.
    p_quad_no_word1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_QUAD) |-> (mask1 == '0));

endmodule

// File: rtl/netirq_status.sv
module netirq_status #(
    parameter int W0 = 32,
    parameter int W1 = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W0-1:0] set0,
    input  logic [W1-1:0] set1,
    input  logic [W0-1:0] clr0,
    input  logic [W1-1:0] clr1,
    output logic [W0-1:0] st0,
    output logic [W1-1:0] st1,
    output logic [W0-1:0] nxt0,
    output logic [W1-1:0] nxt1
);
    always_comb begin
        nxt0 = (st0 & ~clr0) | set0;
        nxt1 = (st1 & ~clr1) | set1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st0 <= '0;
            st1 <= '0;
        end else begin
            st0 <= nxt0;
            st1 <= nxt1;
        end
    end

    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set0) |=> ((st0 & $past(set0)) == $past(set0)));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set0 & clr0)) |=> ((st0 & $past(set0 & clr0)) == $past(set0 & clr0)));

    p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr0 & ~set0)) |=> ((st0 & $past(clr0 & ~set0)) == '0));

    p_untouched_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st0 & ~$past(set0 | clr0)) == ($past(st0) & ~$past(set0 | clr0))));

endmodule

// File: rtl/netirq_readmux.sv
module netirq_readmux
    import netirq_pkg::*;
#(
    parameter int W0    = 32,
    parameter int W1    = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chassis_mode_e    mode,
    input  logic [SEL_W-1:0] sel,
    input  logic [W0-1:0]    st0,
    input  logic [W1-1:0]    st1,
    output logic [W0-1:0]    rd_data
);
    localparam int LANES = W0 / 8;
    localparam int LW    = $clog2(LANES);
    localparam logic [SEL_W-1:0] SEL_LANES = SEL_W'(LANES);

    logic [7:0] lane [LANES];

    // Lane 0 is the top byte: select order runs from the high byte down.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = st0[W0-1-8*g -: 8];
    end

    always_comb begin
        rd_data = '0;
        if (mode == MODE_QUAD) begin
            if (sel < SEL_LANES) rd_data = {{(W0-8){1'b0}}, lane[sel[LW-1:0]]};
        end else begin
            if (sel == SEL_W'(0))      rd_data = st0;
            else if (sel == SEL_W'(1)) rd_data = W0'(st1);
        end
    end

    p_spare_sel_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SEPT && sel > SEL_W'(1)) |-> (rd_data == '0));

endmodule

// File: rtl/netirq_collector.sv
module netirq_collector
    import netirq_pkg::*;
#(
    parameter int W0         = 32,
    parameter int W1         = 8,
    parameter int SLOT_W     = 3,
    parameter int PORT_W     = 3,
    parameter int SEL_W      = 3,
    parameter int PORTS      = 4,
    parameter int SLOTS_QUAD = 4,
    parameter int SLOTS_SEPT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              set_vld_i,
    input  logic [SLOT_W-1:0] set_slot_i,
    input  logic [PORT_W-1:0] set_port_i,
    input  logic              clr_vld_i,
    input  logic [SLOT_W-1:0] clr_slot_i,
    input  logic [PORT_W-1:0] clr_port_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [W0-1:0]     rd_data_o,
    output logic              irq_o
);
    localparam int REQS = 2; // index 0 raises, index 1 drops

    chassis_mode_e mode_q;
    irq_state_e    st_q, st_n;

    logic              req_vld  [REQS];
    logic [SLOT_W-1:0] req_slot [REQS];
    logic [PORT_W-1:0] req_port [REQS];
    logic [W0-1:0]     m0 [REQS];
    logic [W1-1:0]     m1 [REQS];
    logic [W0-1:0]     st0, nxt0;
    logic [W1-1:0]     st1, nxt1;
    logic              any_next;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= chassis_mode_e'(mode_i);
    end

    assign req_vld[0]  = set_vld_i;
    assign req_slot[0] = set_slot_i;
    assign req_port[0] = set_port_i;
    assign req_vld[1]  = clr_vld_i;
    assign req_slot[1] = clr_slot_i;
    assign req_port[1] = clr_port_i;

    for (genvar r = 0; r < REQS; r++) begin : g_req
        netirq_decode #(
            .W0(W0), .W1(W1), .SLOT_W(SLOT_W), .PORT_W(PORT_W),
            .PORTS(PORTS), .SLOTS_QUAD(SLOTS_QUAD), .SLOTS_SEPT(SLOTS_SEPT)
        ) u_dec (
            .clk  (clk),
            .rst_n(rst_n),
            .mode (mode_q),
            .vld  (req_vld[r]),
            .slot (req_slot[r]),
            .port (req_port[r]),
            .mask0(m0[r]),
            .mask1(m1[r])
        );
    end

    netirq_status #(.W0(W0), .W1(W1)) u_status (
        .clk (clk),
        .rst_n(rst_n),
        .set0(m0[0]),
        .set1(m1[0]),
        .clr0(m0[1]),
        .clr1(m1[1]),
        .st0 (st0),
        .st1 (st1),
        .nxt0(nxt0),
        .nxt1(nxt1)
    );

    netirq_readmux #(.W0(W0), .W1(W1), .SEL_W(SEL_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode_q),
        .sel    (rd_sel_i),
        .st0    (st0),
        .st1    (st1),
        .rd_data(rd_data_o)
    );

    // Interrupt controller
    assign any_next = (|nxt0) || ((mode_q == MODE_SEPT) && (|nxt1));

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_QUIET;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_QUIET:  if (any_next)  st_n = ST_RAISED; // raise
            ST_RAISED: if (!any_next) st_n = ST_QUIET;  // settle
        endcase
    end

    always_comb begin
        irq_o = (st_q == ST_RAISED);
    end

    p_irq_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((|st0) || ((mode_q == MODE_SEPT) && (|st1))));

    p_mode_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mode_q));

endmodule

// File: tb/netirq_collector_bench.sv
module netirq_collector_bench;
    localparam int PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0;
    logic        set_vld_i = 1'b0, clr_vld_i = 1'b0;
    logic [2:0]  set_slot_i = '0, set_port_i = '0, clr_slot_i = '0, clr_port_i = '0;
    logic [2:0]  rd_sel_i = '0;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    bit [31:0] r0;
    bit [7:0]  r1;
    bit        rmode;

    always #(PERIOD/2) clk = ~clk;

    netirq_collector u_netirq_collector (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .set_vld_i(set_vld_i), .set_slot_i(set_slot_i), .set_port_i(set_port_i),
        .clr_vld_i(clr_vld_i), .clr_slot_i(clr_slot_i), .clr_port_i(clr_port_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    function automatic void model_mask(input bit v, input int s, input int p,
                                       output bit [31:0] w0, output bit [7:0] w1);
        int quad_base [4] = '{16, 24, 0, 8};
        int sept_base [7] = '{0, 24, 16, 28, 20, 8, 0};
        int lim = rmode ? 7 : 4;
        w0 = '0;
        w1 = '0;
        if (v && s < lim && p < 4) begin
            if (rmode && s == 0)  w1[p] = 1'b1;
            else if (rmode)       w0[sept_base[s] + p] = 1'b1;
            else                  w0[quad_base[s] + p] = 1'b1;
        end
    endfunction

    function automatic bit [31:0] model_read(input int sel);
        if (!rmode) return (sel < 4) ? ((r0 >> (24 - 8*sel)) & 32'hFF) : 32'h0;
        if (sel == 0) return r0;
        if (sel == 1) return {24'h0, r1};
        return 32'h0;
    endfunction

    task automatic check_all(input string tag);
        bit exp_irq = (r0 != 0) || (rmode && r1 != 0);
        checks++;
        if (irq_o !== exp_irq) begin
            fails++;
            $display("FAIL R9 (after %s) irq actual=%b expected=%b", tag, irq_o, exp_irq);
        end
        for (int s = 0; s < 5; s++) begin
            rd_sel_i = 3'(s);
            #1;
            checks++;
            if (rd_data_o !== model_read(s)) begin
                fails++;
                $display("FAIL %s (after %s) sel=%0d actual=%h expected=%h",
                         rmode ? "R8" : "R6", tag, s, rd_data_o, model_read(s));
            end
        end
    endtask

    task automatic step(input bit sv, input int ss, input int sp,
                        input bit cv, input int cs, input int cp, input string tag);
        bit [31:0] s0, c0;
        bit [7:0]  s1, c1;
        @(negedge clk);
        set_vld_i = sv; set_slot_i = 3'(ss); set_port_i = 3'(sp);
        clr_vld_i = cv; clr_slot_i = 3'(cs); clr_port_i = 3'(cp);
        @(posedge clk);
        model_mask(sv, ss, sp, s0, s1);
        model_mask(cv, cs, cp, c0, c1);
        r0 = (r0 & ~c0) | s0;
        r1 = (r1 & ~c1) | s1;
        #1;
        check_all(tag);
    endtask

    task automatic do_reset(input bit m);
        @(negedge clk);
        rst_n = 1'b0; mode_i = m;
        set_vld_i = 1'b0; clr_vld_i = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        r0 = '0; r1 = '0; rmode = m;
        check_all("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_all("R1 after reset");
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++)
            step($urandom_range(0, 1) == 1, $urandom_range(0, 7), $urandom_range(0, 5),
                 $urandom_range(0, 2) == 0, $urandom_range(0, 7), $urandom_range(0, 5),
                 "random R2 R3 R10");
    endtask

    initial begin
        // four-slot mode
        do_reset(1'b0);
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 4; p++) step(1, s, p, 0, 0, 0, "R5 placement");
        step(0, 0, 0, 1, 1, 2, "R3 single drop");
        step(0, 0, 0, 1, 2, 0, "R3 single drop");
        step(1, 3, 1, 1, 3, 1, "R4 same bit");
        step(1, 1, 2, 1, 1, 2, "R4 re-raise");
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 4; p++) step(0, 0, 0, 1, s, p, "R3 drain");
        step(1, 4, 0, 0, 0, 0, "R10 slot 4");
        step(1, 6, 1, 0, 0, 0, "R10 slot 6");
        step(1, 2, 4, 0, 0, 0, "R10 port 4");
        step(1, 0, 7, 0, 0, 0, "R10 port 7");
        step(1, 2, 3, 0, 0, 0, "R2 raise");
        step(0, 0, 0, 1, 2, 5, "R10 drop port 5");
        @(negedge clk);
        mode_i = 1'b1;
        step(1, 5, 0, 0, 0, 0, "R11 mode flip slot 5");
        step(1, 0, 0, 0, 0, 0, "R11 mode flip slot 0");
        random_run(400);

        // seven-slot mode
        do_reset(1'b1);
        for (int s = 0; s < 7; s++)
            for (int p = 0; p < 4; p++) step(1, s, p, 0, 0, 0, "R7 placement");
        step(1, 7, 0, 0, 0, 0, "R10 slot 7");
        step(0, 0, 0, 1, 0, 2, "R3 word1 drop");
        step(1, 0, 2, 1, 0, 2, "R4 word1 same bit");
        for (int s = 1; s < 7; s++)
            for (int p = 0; p < 4; p++) step(0, 0, 0, 1, s, p, "R3 drain word0");
        step(0, 0, 0, 1, 0, 0, "R9 word1 only");
        for (int p = 1; p < 4; p++) step(0, 0, 0, 1, 0, p, "R9 all clear");
        @(negedge clk);
        mode_i = 1'b0;
        step(1, 6, 3, 0, 0, 0, "R11 mode flip slot 6");
        step(1, 0, 1, 0, 0, 0, "R11 mode flip slot 0");
        random_run(400);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule